// File: doc/BRIEF.md
# Indirect Register Access Sequencer

This block lets a client read or write a 16-bit top-level register that sits behind an indirect access port. The port is reached over a 32-bit register bus. The client gives an address, a 16-bit write value, a direction flag and a one-cycle start pulse. The sequencer then runs the whole bus exchange by itself and raises `done` for one cycle, with the result and a 2-bit error code.

Every access begins by writing a control word to the port's control register. The control word holds a transformed form of the client address. A write then stores the data word and issues the write command. A read issues the read command and then polls the port's result register. Polling continues until the ready flag appears or the retry budget is used up. The result carries a two-bit status, and every failure returns all-ones data. The bus side is a request/acknowledge master. A transfer completes in each cycle where request and acknowledge are both high.

Top module: `ind_reg_seq`

## Requirements
- R1: The control word written first is the client address shifted right by one bit, plus 0x30000, as an unsigned 32-bit value.
- R2: A write access performs exactly three bus writes, in this order. First the control register. Then the write-data register, carrying the 16-bit value zero-extended to 32 bits. Then the command register, carrying the value 1.
- R3: A read access writes the control register, then writes the value 2 to the command register, and then issues bus reads of the result register.
- R4: The ready flag is bit 18 of the polled word. Polling stops at the first word that has it set. If bits 17:16 of that word equal 1 (OK), `rdata` returns its bits 15:0 and `err_code` is 0.
- R5: At most POLL_MAX reads (default 32) are issued. If none of them has the ready flag set, the access ends with `err_code` = 1 (timeout) and `rdata` = 0xFFFF.
- R6: If the ready word's status is 0 (no response), 2 (request failed) or 3 (response error), the access ends with `err_code` = 2 and `rdata` = 0xFFFF.
- R7: `done` is high for exactly one cycle per access. For a write, `done` comes in the cycle after the command write is acknowledged, with `err_code` 0 and no bus reads issued.
- R8: `busy` is high from the cycle after an accepted start until the cycle in which `done` is high; in that cycle `busy` is already low. A start pulse while `busy` is high is ignored: it causes no bus transfer and no `done`.
- R9: While `bus_req` is high and `bus_ack` is low, the request and its address, direction and write data stay unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin an access |
| wr_en | input | 1 | Direction flag: 1 is a write, 0 is a read |
| addr | input | CLI_AW | Client register address |
| wdata | input | 16 | Value to write |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result; 0xFFFF on failure |
| err_code | output | 2 | 0 none, 1 timeout, 2 bad status; valid with done |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | Bus transfer is a write |
| bus_addr | output | BUS_AW | Bus register offset |
| bus_wdata | output | 32 | Bus write data |
| bus_ack | input | 1 | Transfer accepted this cycle |
| bus_rdata | input | 32 | Read data, valid with bus_ack |

## Verification
The bench places the ready flag on the first read, on a middle read and on the very last permitted read. It also tests a target that never becomes ready. A counter that is off by one would either time out on the 32nd read or issue a 33rd read. Each non-OK status code is returned once. A decoder that tests only one status bit would then pass real data through as valid. The bench also checks odd addresses and the maximum address, which catches a missing shift or a missing offset. It checks the zero-extension of the write value and the exact count of bus transfers, which catches a write that polls. A start pulse arrives in the middle of a slow read. A design that accepts it would run extra transfers or produce a second `done`.

// File: rtl/ind_reg_pkg.sv
package ind_reg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CTRL  = 3'd1,
        ST_WDATA = 3'd2,
        ST_CMD   = 3'd3,
        ST_POLL  = 3'd4
    } seq_state_e;

    localparam logic [1:0]  ERR_NONE    = 2'd0;
    localparam logic [1:0]  ERR_TIMEOUT = 2'd1;
    localparam logic [1:0]  ERR_STATUS  = 2'd2;

    localparam logic [31:0] CMD_WORD_WR = 32'd1;
    localparam logic [31:0] CMD_WORD_RD = 32'd2;

    localparam logic [1:0]  STAT_OK     = 2'd1;
    localparam logic [31:0] ADDR_BIAS   = 32'h0003_0000;
    localparam logic [15:0] FAIL_DATA   = 16'hFFFF;

    typedef struct packed {
        seq_state_e  state;
        logic        op_wr;
        logic [31:0] ctrl_word;
        logic [15:0] wdata;
        logic [15:0] rdata;
        logic [1:0]  err;
        logic        done;
    } seq_regs_t;

endpackage

// File: rtl/ind_addr_xform.sv
module ind_addr_xform #(
    parameter int CLI_AW = 16
) (
    input  logic [CLI_AW-1:0] cli_addr,
    output logic [31:0]       ctrl_word
);
    import ind_reg_pkg::*;

    localparam int PAD = 32 - CLI_AW;

    logic [31:0] wide_addr;

    generate
        if (PAD > 0) begin : g_pad
            assign wide_addr = {{PAD{1'b0}}, cli_addr};
        end else begin : g_nopad
            assign wide_addr = cli_addr[31:0];
        end
    endgenerate

    always_comb begin
        ctrl_word = (wide_addr >> 1) + ADDR_BIAS;
    end

endmodule

// File: rtl/ind_poll_decode.sv
module ind_poll_decode #(
    parameter int READY_POS = 18,
    parameter int STAT_LSB  = 16
) (
    input  logic [31:0] word,
    output logic        ready,
    output logic        stat_ok,
    output logic [15:0] payload
);
    import ind_reg_pkg::*;

    logic [1:0] stat;

    always_comb begin
        ready   = word[READY_POS];
        stat    = word[STAT_LSB +: 2];
        stat_ok = (stat == STAT_OK);
        payload = word[15:0];
    end

endmodule

// File: rtl/ind_retry_ctr.sv
module ind_retry_ctr #(
    parameter int MAX = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = (MAX > 1) ? $clog2(MAX) : 1;
    localparam logic [CW-1:0] LAST_VAL = CW'(MAX - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = (cnt_q == LAST_VAL);

    // R5: the sequencer must end polling at the last read, never step past it
    p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc && !clr && last));

endmodule

// File: rtl/ind_reg_seq.sv
module ind_reg_seq #(
    parameter int                  CLI_AW    = 16,
    parameter int                  BUS_AW    = 16,
    parameter int                  POLL_MAX  = 32,
    parameter logic [BUS_AW-1:0]   OFS_CTRL  = 16'h0100,
    parameter logic [BUS_AW-1:0]   OFS_WDATA = 16'h0104,
    parameter logic [BUS_AW-1:0]   OFS_RDATA = 16'h0108,
    parameter logic [BUS_AW-1:0]   OFS_CMD   = 16'h010C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wr_en,
    input  logic [CLI_AW-1:0] addr,
    input  logic [15:0]       wdata,
    output logic              busy,
    output logic              done,
    output logic [15:0]       rdata,
    output logic [1:0]        err_code,
    output logic              bus_req,
    output logic              bus_we,
    output logic [BUS_AW-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic              bus_ack,
    input  logic [31:0]       bus_rdata
);
    import ind_reg_pkg::*;

    seq_regs_t r_d, r_q;

    logic [31:0] new_ctrl;
    logic        pw_ready, pw_ok;
    logic [15:0] pw_payload;
    logic        ctr_clr, ctr_inc, ctr_last;

    ind_addr_xform #(.CLI_AW(CLI_AW)) u_xform (
        .cli_addr  (addr),
        .ctrl_word (new_ctrl)
    );

    ind_poll_decode #(.READY_POS(18), .STAT_LSB(16)) u_decode (
        .word    (bus_rdata),
        .ready   (pw_ready),
        .stat_ok (pw_ok),
        .payload (pw_payload)
    );

    ind_retry_ctr #(.MAX(POLL_MAX)) u_retry (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctr_clr),
        .inc   (ctr_inc),
        .last  (ctr_last)
    );

    // bus port: fields come only from registered state, so they hold until ack
    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        unique case (r_q.state)
            ST_CTRL: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = OFS_CTRL;
                bus_wdata = r_q.ctrl_word;
            end
            ST_WDATA: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = OFS_WDATA;
                bus_wdata = {16'h0000, r_q.wdata};
            end
            ST_CMD: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = OFS_CMD;
                bus_wdata = r_q.op_wr ? CMD_WORD_WR : CMD_WORD_RD;
            end
            ST_POLL: begin
                bus_req   = 1'b1;
                bus_we    = 1'b0;
                bus_addr  = OFS_RDATA;
            end
            default: begin
                bus_req   = 1'b0;
            end
        endcase
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        ctr_clr  = 1'b0;
        ctr_inc  = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.state     = ST_CTRL;
                    r_d.op_wr     = wr_en;
                    r_d.ctrl_word = new_ctrl;
                    r_d.wdata     = wdata;
                    ctr_clr       = 1'b1;
                end
            end
            ST_CTRL: begin
                if (bus_ack) begin
                    r_d.state = r_q.op_wr ? ST_WDATA : ST_CMD;
                end
            end
            ST_WDATA: begin
                if (bus_ack) begin
                    r_d.state = ST_CMD;
                end
            end
            ST_CMD: begin
                if (bus_ack) begin
                    if (r_q.op_wr) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                        r_d.err   = ERR_NONE;
                        r_d.rdata = 16'h0000;
                    end else begin
                        r_d.state = ST_POLL;
                        ctr_clr   = 1'b1;
                    end
                end
            end
            ST_POLL: begin
                if (bus_ack) begin
                    if (pw_ready) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                        if (pw_ok) begin
                            r_d.rdata = pw_payload;
                            r_d.err   = ERR_NONE;
                        end else begin
                            r_d.rdata = FAIL_DATA;
                            r_d.err   = ERR_STATUS;
                        end
                    end else if (ctr_last) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                        r_d.rdata = FAIL_DATA;
                        r_d.err   = ERR_TIMEOUT;
                    end else begin
                        ctr_inc = 1'b1;
                    end
                end
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state     <= ST_IDLE;
            r_q.op_wr     <= 1'b0;
            r_q.ctrl_word <= '0;
            r_q.wdata     <= '0;
            r_q.rdata     <= '0;
            r_q.err       <= ERR_NONE;
            r_q.done      <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.state != ST_IDLE);
    assign done     = r_q.done;
    assign rdata    = r_q.rdata;
    assign err_code = r_q.err;

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_write_no_poll_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |-> !r_q.op_wr);

    p_busy_low_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(r_q.op_wr) && $stable(r_q.ctrl_word));

    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> bus_req && $stable(bus_addr)
                                  && $stable(bus_we) && $stable(bus_wdata));

    p_fail_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code != ERR_NONE) |-> rdata == 16'hFFFF);

endmodule

// File: tb/ind_reg_seq_test.sv
module ind_reg_seq_test;

    localparam logic [15:0] O_CTRL  = 16'h0100;
    localparam logic [15:0] O_WDATA = 16'h0104;
    localparam logic [15:0] O_RDATA = 16'h0108;
    localparam logic [15:0] O_CMD   = 16'h010C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] addr = '0;
    logic [15:0] wdata = '0;
    logic        busy, done;
    logic [15:0] rdata;
    logic [1:0]  err_code;
    logic        bus_req, bus_we;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;

    int errors = 0;
    int checks = 0;

    // responder script and log
    int          ack_delay = 0;
    int          ready_at  = 1;
    logic [1:0]  rsp_stat  = 2'd1;
    logic [15:0] rsp_data  = 16'h0000;
    logic [15:0] lg_addr [64];
    logic [31:0] lg_data [64];
    logic        lg_we   [64];
    int          lg_n = 0;
    int          rd_n = 0;
    int          wait_cnt = 0;
    int          done_seen = 0;

    ind_reg_seq #(
        .CLI_AW(16), .BUS_AW(16), .POLL_MAX(32),
        .OFS_CTRL(O_CTRL), .OFS_WDATA(O_WDATA),
        .OFS_RDATA(O_RDATA), .OFS_CMD(O_CMD)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .busy(busy), .done(done),
        .rdata(rdata), .err_code(err_code), .bus_req(bus_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    always #5 clk = ~clk;

    // bus responder: decides at the falling edge, design samples at the rising edge
    initial begin
        forever begin
            @(negedge clk);
            bus_ack   = 1'b0;
            bus_rdata = 32'h0;
            if (done) done_seen++;
            if (bus_req) begin
                if (wait_cnt < ack_delay) begin
                    wait_cnt++;
                end else begin
                    wait_cnt = 0;
                    if (lg_n < 64) begin
                        lg_addr[lg_n] = bus_addr;
                        lg_data[lg_n] = bus_wdata;
                        lg_we[lg_n]   = bus_we;
                    end
                    lg_n++;
                    if (!bus_we) begin
                        rd_n++;
                        if (ready_at != 0 && rd_n >= ready_at)
                            bus_rdata = {13'h0, 1'b1, rsp_stat, rsp_data};
                        else
                            bus_rdata = 32'h0003_5A5A;
                    end
                    bus_ack = 1'b1;
                end
            end
        end
    end

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, act=timeout exp=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        lg_n = 0;
        rd_n = 0;
        wait_cnt = 0;
        done_seen = 0;
    endtask

    task automatic launch(input bit wr, input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = wr;
        addr  = a;
        wdata = d;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check(done == 1'b1, "R7 done reached", {31'b0, done}, 32'h1);
    endtask

    function automatic logic [31:0] ctrl_of(input logic [15:0] a);
        return {16'h0, a} / 2 + 32'h0003_0000;
    endfunction

    task automatic t_reset();
        check(busy == 1'b0, "R8 reset busy", {31'b0, busy}, 0);
        check(done == 1'b0, "R7 reset done", {31'b0, done}, 0);
        check(bus_req == 1'b0, "R9 reset bus_req", {31'b0, bus_req}, 0);
    endtask

    task automatic t_write(input logic [15:0] a, input logic [15:0] d);
        clear_log();
        launch(1'b1, a, d);
        wait_done();
        check(err_code == 2'd0, "R7 write err", {30'b0, err_code}, 0);
        check(lg_n == 3, "R2 write count", lg_n, 3);
        check(lg_addr[0] == O_CTRL && lg_we[0], "R2 first ctrl", {16'h0, lg_addr[0]}, {16'h0, O_CTRL});
        check(lg_data[0] == ctrl_of(a), "R1 ctrl word", lg_data[0], ctrl_of(a));
        check(lg_addr[1] == O_WDATA && lg_we[1], "R2 second wdata", {16'h0, lg_addr[1]}, {16'h0, O_WDATA});
        check(lg_data[1] == {16'h0, d}, "R2 wdata zero-ext", lg_data[1], {16'h0, d});
        check(lg_addr[2] == O_CMD && lg_data[2] == 32'd1, "R2 cmd write", lg_data[2], 1);
        @(negedge clk);
        check(done == 1'b0, "R7 done one cycle", {31'b0, done}, 0);
        check(rd_n == 0, "R7 write no poll", rd_n, 0);
    endtask

    task automatic t_read(input logic [15:0] a, input int rdy, input logic [1:0] st,
                          input logic [15:0] d, input int dly);
        int exp_reads;
        logic [15:0] exp_data;
        logic [1:0]  exp_err;
        ready_at = rdy;
        rsp_stat = st;
        rsp_data = d;
        ack_delay = dly;
        clear_log();
        launch(1'b0, a, 16'hDEAD);
        check(busy == 1'b1, "R8 busy after start", {31'b0, busy}, 1);
        wait_done();
        check(busy == 1'b0, "R8 busy low with done", {31'b0, busy}, 0);
        if (rdy == 0 || rdy > 32) begin
            exp_reads = 32; exp_data = 16'hFFFF; exp_err = 2'd1;
        end else begin
            exp_reads = rdy;
            exp_data = (st == 2'd1) ? d : 16'hFFFF;
            exp_err  = (st == 2'd1) ? 2'd0 : 2'd2;
        end
        check(lg_addr[0] == O_CTRL && lg_data[0] == ctrl_of(a), "R1 R3 read ctrl", lg_data[0], ctrl_of(a));
        check(lg_addr[1] == O_CMD && lg_data[1] == 32'd2 && lg_we[1], "R3 read cmd", lg_data[1], 2);
        check(lg_addr[2] == O_RDATA && !lg_we[2], "R3 poll addr", {16'h0, lg_addr[2]}, {16'h0, O_RDATA});
        check(rd_n == exp_reads, "R4 R5 poll count", rd_n, exp_reads);
        check(rdata == exp_data, "R4 R5 R6 rdata", {16'h0, rdata}, {16'h0, exp_data});
        check(err_code == exp_err, "R4 R5 R6 err_code", {30'b0, err_code}, {30'b0, exp_err});
        ack_delay = 0;
    endtask

    task automatic t_busy_ignore();
        int n;
        ready_at = 3; rsp_stat = 2'd1; rsp_data = 16'h1234; ack_delay = 2;
        clear_log();
        launch(1'b0, 16'h0040, 16'h0);
        repeat (3) @(negedge clk);
        launch(1'b1, 16'h0222, 16'h7777);
        wait_done();
        for (int i = 0; i < 20; i++) @(negedge clk);
        n = lg_n;
        check(n == 5, "R8 ignored start transfers", n, 5);
        check(done_seen == 1, "R8 single done", done_seen, 1);
        check(rdata == 16'h1234, "R8 first op result", {16'h0, rdata}, 32'h1234);
        ack_delay = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_write(16'h0A52, 16'hBEEF);
        t_write(16'h0003, 16'h8001);
        t_write(16'hFFFF, 16'h0000);
        t_read(16'h1000, 3, 2'd1, 16'hC0DE, 0);
        t_read(16'h0001, 1, 2'd1, 16'h55AA, 0);
        t_read(16'h0200, 32, 2'd1, 16'h0F0F, 0);
        t_read(16'h0200, 0, 2'd1, 16'h0F0F, 0);
        t_read(16'h0300, 2, 2'd0, 16'h1111, 0);
        t_read(16'h0300, 2, 2'd2, 16'h2222, 0);
        t_read(16'h0300, 4, 2'd3, 16'h3333, 0);
        t_read(16'h7FFE, 2, 2'd1, 16'hA5A5, 3);
        t_busy_ignore();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule